// File: doc/BRIEF.md
# Gate driver fault supervisor

This block sits beside the four gate drivers of a full-bridge MOSFET pre-driver and makes the fault decisions. It takes four kinds of monitor flags. The first is a junction overtemperature flag. The second is an undervoltage flag for the gate-drive regulator. The third is an undervoltage flag for the logic supply. The last is a bootstrap charge timeout flag for each phase. From these it produces three results: an active-low fault indication meant to pull an open-drain pin, a global disable for the gate outputs, and a code that names the fault with the highest priority. The faults do not behave alike. Overtemperature only warns. Regulator undervoltage blocks the outputs and recovers on its own. A bootstrap timeout stays latched. Logic-supply undervoltage wipes every other fault state and takes its place.

The same block decodes the active-low wake/reset pin with a small state machine whose states are `PS_RUN`, `PS_LOWCNT`, `PS_SLEEP` and `PS_SETTLE`:

- `PS_RUN`: normal operation. A low sample moves the machine to `PS_LOWCNT`.
- `PS_LOWCNT`: counts consecutive low samples. A release after no more than `SLEEP_CNT` samples is a clear pulse, and the machine returns to `PS_RUN`. Reaching the count moves the machine to `PS_SLEEP`.
- `PS_SLEEP`: gate outputs are disabled and the fault pin is released. A high sample moves the machine to `PS_SETTLE`.
- `PS_SETTLE`: holds the charge-pump settling inhibit for `SETTLE_CNT` cycles and then returns to `PS_RUN`. A low sample in this state goes back to `PS_LOWCNT`.

Every input, the pin included, passes through a two-flop synchroniser before it is used.

Top module: `gdrv_fault_sup`

## Requirements
- R1: Each input flag and the wake pin passes through two synchronising flops. A change at an input cannot reach any output before the second rising clock edge after it is applied.
- R2: Overtemperature, while flagged, gives fault code 1 and pulls `fault_n` low. It never sets `out_dis`. It follows the flag and is not latched.
- R3: Regulator undervoltage gives fault code 2 and sets `out_dis`. It clears by itself once the flag drops.
- R4: A timeout pulse on any phase's bootstrap flag latches a bootstrap fault, which gives fault code 3 and sets `out_dis`. The latch holds after the flag drops.
- R5: Logic-supply undervoltage gives fault code 4 and sets `out_dis`. While it is present, every bootstrap latch is cleared and kept clear, so no bootstrap fault remains once it ends.
- R6: When several faults are present, the reported code follows this priority, highest first: logic-supply undervoltage (4), bootstrap (3), regulator undervoltage (2), overtemperature (1). Code 0 means no fault.
- R7: From reset, the regulator and logic-supply undervoltage faults are both treated as present. Each clears only after its flag has been seen low through the synchroniser.
- R8: A wake pin low for 1 to `SLEEP_CNT` synchronised samples, then released, clears the bootstrap latches and does not enter sleep.
- R9: A wake pin low for more than `SLEEP_CNT` samples enters sleep. In sleep, `sleep` is 1, `out_dis` is 1, `fault_n` is released to 1, and the fault code is 0. In sleep the bootstrap latches are cleared and timeout pulses are ignored.
- R10: On release from sleep, `cp_inhibit` and `out_dis` are held for exactly `SETTLE_CNT` cycles before normal operation resumes.
- R11: `fault_n` is 0 exactly when the fault code is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| ot_flag | input | 1 | Overtemperature monitor flag, high while too hot (hysteresis is in the comparator) |
| vreg_uv_flag | input | 1 | Regulator undervoltage flag, high while low |
| vdd_uv_flag | input | 1 | Logic-supply undervoltage flag, high while low |
| boot_to | input | NPH | Per-phase bootstrap charge timeout pulses |
| wake_n | input | 1 | Active-low wake/reset pin: a short low clears latched faults, a long low sleeps |
| fault_n | output | 1 | Open-drain pull control: 0 pulls the fault pin low, 1 releases it |
| out_dis | output | 1 | Global gate-output disable |
| sleep | output | 1 | Block is in sleep |
| cp_inhibit | output | 1 | Charge-pump settling inhibit after wake |
| fault_code | output | 3 | Highest-priority fault: 0 none, 1 overtemp, 2 regulator UV, 3 bootstrap, 4 logic-supply UV |

## Verification
The bench sweeps every combination of the three level faults and both phase latches. It fires the timeouts before the supply fault rises, so a design that let bootstrap latches survive a logic-supply undervoltage would report code 3 after that undervoltage ends. The same sweep catches a priority slip or an overtemperature that disables the outputs. The wake pin is driven low for exactly `SLEEP_CNT` and for `SLEEP_CNT`+1 samples. An off-by-one in the low counter would sleep on a clear pulse or miss sleep on a long one. The bench also counts the inhibit cycles after wake, the power-up state before the supply flags are seen low, and the two-edge latency of the synchroniser.

// File: rtl/gfs_pkg.sv
package gfs_pkg;

    typedef enum logic [2:0] {
        FC_NONE = 3'd0,
        FC_OT   = 3'd1,
        FC_VREG = 3'd2,
        FC_BOOT = 3'd3,
        FC_VDD  = 3'd4
    } fault_code_e;

    typedef enum logic [1:0] {
        PS_RUN    = 2'd0,
        PS_LOWCNT = 2'd1,
        PS_SLEEP  = 2'd2,
        PS_SETTLE = 2'd3
    } pin_state_e;

endpackage

// File: rtl/gfs_sync.sv
module gfs_sync #(
    parameter int             W       = 4,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[i] <= RST_VAL[i];
                q[i]      <= RST_VAL[i];
            end else begin
                stage1[i] <= d[i];
                q[i]      <= stage1[i];
            end
        end
    end

endmodule

// File: rtl/gfs_pin_fsm.sv
module gfs_pin_fsm
    import gfs_pkg::*;
#(
    parameter int SLEEP_CNT  = 50000,
    parameter int SETTLE_CNT = 150000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_s,
    output logic sleep,
    output logic inhibit,
    output logic clr_pulse
);

    localparam int CMAX = (SLEEP_CNT > SETTLE_CNT) ? SLEEP_CNT : SETTLE_CNT;
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] SLEEP_LAST  = CW'(SLEEP_CNT - 1);
    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CNT - 1);

    pin_state_e    state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    // next-state logic
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            PS_RUN: begin
                if (!wake_s) begin
                    state_nx = PS_LOWCNT;
                    cnt_nx   = '0;
                end
            end
            PS_LOWCNT: begin
                if (wake_s) begin
                    state_nx = PS_RUN;
                end else if (cnt == SLEEP_LAST) begin
                    state_nx = PS_SLEEP;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            PS_SLEEP: begin
                if (wake_s) begin
                    state_nx = PS_SETTLE;
                    cnt_nx   = '0;
                end
            end
            PS_SETTLE: begin
                if (!wake_s) begin
                    state_nx = PS_LOWCNT;
                    cnt_nx   = '0;
                end else if (cnt == SETTLE_LAST) begin
                    state_nx = PS_RUN;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            default: state_nx = PS_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PS_RUN;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // outputs
    always_comb begin
        sleep     = 1'b0;
        inhibit   = 1'b0;
        clr_pulse = 1'b0;
        unique case (state)
            PS_RUN:    ;
            PS_LOWCNT: clr_pulse = wake_s;
            PS_SLEEP:  sleep     = 1'b1;
            PS_SETTLE: inhibit   = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/gfs_fault_core.sv
module gfs_fault_core
    import gfs_pkg::*;
#(
    parameter int NPH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ot_s,
    input  logic           vreg_s,
    input  logic           vdd_s,
    input  logic [NPH-1:0] boot_s,
    input  logic           sleep,
    input  logic           inhibit,
    input  logic           clr_pulse,
    output logic [2:0]     fault_code,
    output logic           fault_n,
    output logic           out_dis
);

    logic [NPH-1:0] boot_lat;
    logic           boot_any;
    fault_code_e    code;

    // per-phase bootstrap latches; wipe has priority over set
    for (genvar p = 0; p < NPH; p++) begin : g_phase
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                boot_lat[p] <= 1'b0;
            end else if (vdd_s || sleep || clr_pulse) begin
                boot_lat[p] <= 1'b0;
            end else if (boot_s[p]) begin
                boot_lat[p] <= 1'b1;
            end
        end
    end

    assign boot_any = |boot_lat;

    // priority encoding of the reported fault
    always_comb begin
        if (sleep)         code = FC_NONE;
        else if (vdd_s)    code = FC_VDD;
        else if (boot_any) code = FC_BOOT;
        else if (vreg_s)   code = FC_VREG;
        else if (ot_s)     code = FC_OT;
        else               code = FC_NONE;
    end

    assign fault_code = code;
    assign fault_n    = (code == FC_NONE);
    assign out_dis    = sleep | inhibit | vdd_s | vreg_s | boot_any;

endmodule

// File: rtl/gdrv_fault_sup.sv
module gdrv_fault_sup #(
    parameter int NPH        = 2,
    parameter int SLEEP_CNT  = 50000,
    parameter int SETTLE_CNT = 150000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ot_flag,
    input  logic           vreg_uv_flag,
    input  logic           vdd_uv_flag,
    input  logic [NPH-1:0] boot_to,
    input  logic           wake_n,
    output logic           fault_n,
    output logic           out_dis,
    output logic           sleep,
    output logic           cp_inhibit,
    output logic [2:0]     fault_code
);

    localparam int IDX_OT   = NPH;
    localparam int IDX_VREG = NPH + 1;
    localparam int IDX_VDD  = NPH + 2;
    localparam int IDX_WAKE = NPH + 3;
    localparam int SW       = NPH + 4;
    // supplies start in fault, the pin starts released
    localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b1, 1'b1, 1'b0, {NPH{1'b0}}};

    logic [SW-1:0] raw_in, syn;
    logic          clr_pulse;

    assign raw_in = {wake_n, vdd_uv_flag, vreg_uv_flag, ot_flag, boot_to};

    gfs_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn)
    );

    gfs_pin_fsm #(.SLEEP_CNT(SLEEP_CNT), .SETTLE_CNT(SETTLE_CNT)) u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake_s    (syn[IDX_WAKE]),
        .sleep     (sleep),
        .inhibit   (cp_inhibit),
        .clr_pulse (clr_pulse)
    );

    gfs_fault_core #(.NPH(NPH)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .ot_s       (syn[IDX_OT]),
        .vreg_s     (syn[IDX_VREG]),
        .vdd_s      (syn[IDX_VDD]),
        .boot_s     (syn[NPH-1:0]),
        .sleep      (sleep),
        .inhibit    (cp_inhibit),
        .clr_pulse  (clr_pulse),
        .fault_code (fault_code),
        .fault_n    (fault_n),
        .out_dis    (out_dis)
    );

endmodule

// File: rtl/gdrv_fault_sup_chk.sv
module gdrv_fault_sup_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fault_n,
    input logic       out_dis,
    input logic       sleep,
    input logic       cp_inhibit,
    input logic [2:0] fault_code
);

    assert_ot_no_disable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code == 3'd1 && !sleep && !cp_inhibit) |-> !out_dis);

    assert_vreg_disables_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code == 3'd2) |-> out_dis);

    assert_boot_disables_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code == 3'd3) |-> out_dis);

    assert_vdd_disables_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code == 3'd4) |-> out_dis);

    assert_code_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fault_code <= 3'd4);

    assert_sleep_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (out_dis && fault_n && fault_code == 3'd0));

    assert_wake_inhibit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep) |-> (cp_inhibit && out_dis));

    assert_modes_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(sleep && cp_inhibit));

    assert_pin_matches_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fault_n == (fault_code == 3'd0));

endmodule

bind gdrv_fault_sup gdrv_fault_sup_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_n    (fault_n),
    .out_dis    (out_dis),
    .sleep      (sleep),
    .cp_inhibit (cp_inhibit),
    .fault_code (fault_code)
);

// File: tb/tb_gdrv_fault_sup.sv
`timescale 1ns/1ps
module tb_gdrv_fault_sup;

    localparam int NPH        = 2;
    localparam int SLEEP_CNT  = 8;
    localparam int SETTLE_CNT = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ot_flag = 1'b0;
    logic           vreg_uv_flag = 1'b1;
    logic           vdd_uv_flag = 1'b1;
    logic [NPH-1:0] boot_to = '0;
    logic           wake_n = 1'b1;
    logic           fault_n, out_dis, sleep, cp_inhibit;
    logic [2:0]     fault_code;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    gdrv_fault_sup #(.NPH(NPH), .SLEEP_CNT(SLEEP_CNT), .SETTLE_CNT(SETTLE_CNT)) dut (
        .clk(clk), .rst_n(rst_n), .ot_flag(ot_flag), .vreg_uv_flag(vreg_uv_flag),
        .vdd_uv_flag(vdd_uv_flag), .boot_to(boot_to), .wake_n(wake_n),
        .fault_n(fault_n), .out_dis(out_dis), .sleep(sleep),
        .cp_inhibit(cp_inhibit), .fault_code(fault_code)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int exp_code(bit vdd, bit bl, bit vreg, bit ot);
        if (vdd)       return 4;
        else if (bl)   return 3;
        else if (vreg) return 2;
        else if (ot)   return 1;
        return 0;
    endfunction

    // low pulse on the wake pin for n cycles, recording whether sleep was seen
    task automatic wake_low(input int n, output bit saw);
        saw = 1'b0;
        wake_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sleep) saw = 1'b1;
        end
        wake_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (sleep) saw = 1'b1;
        end
    endtask

    task automatic latch_boot(input logic [NPH-1:0] b);
        boot_to = b;
        @(negedge clk);
        boot_to = '0;
        wait_cyc(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1..all actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit saw;
        int inh_cnt, dis_cnt;
        wait_cyc(3);
        rst_n = 1'b1;
        // power-up: both supplies treated as faulty
        check("R7", "code at reset", fault_code, 4);
        check("R7", "out_dis at reset", out_dis, 1);
        check("R11", "fault_n at reset", fault_n, 0);
        vdd_uv_flag = 1'b0;
        @(negedge clk);
        check("R1", "code after one edge", fault_code, 4);
        @(negedge clk);
        check("R7", "code with vreg still low", fault_code, 2);
        vreg_uv_flag = 1'b0;
        wait_cyc(3);
        check("R7", "code after supplies up", fault_code, 0);
        check("R7", "out_dis after supplies up", out_dis, 0);
        check("R11", "fault_n idle", fault_n, 1);

        // two-edge latency on overtemperature
        ot_flag = 1'b1;
        @(negedge clk);
        check("R1", "fault_n one edge after ot", fault_n, 1);
        @(negedge clk);
        check("R1", "fault_n two edges after ot", fault_n, 0);
        check("R2", "out_dis under ot", out_dis, 0);
        ot_flag = 1'b0;
        wait_cyc(3);
        check("R2", "ot clears by itself", fault_code, 0);

        // exhaustive sweep: ot, vreg, vdd levels and both phase latches
        for (int c = 0; c < 32; c++) begin
            bit ot, vr, vd, bl;
            logic [NPH-1:0] b;
            ot = c[0]; vr = c[1]; vd = c[2]; b = 2'(c >> 3);
            wake_low(2, saw);
            latch_boot(b);
            ot_flag = ot; vreg_uv_flag = vr; vdd_uv_flag = vd;
            wait_cyc(4);
            bl = (b != 0) && !vd;
            check("R6", $sformatf("code combo %0d", c), fault_code, exp_code(vd, bl, vr, ot));
            check("R5", $sformatf("out_dis combo %0d", c), out_dis, int'(vd | bl | vr));
            check("R11", $sformatf("fault_n combo %0d", c), fault_n,
                  int'(exp_code(vd, bl, vr, ot) == 0));
            ot_flag = 1'b0; vreg_uv_flag = 1'b0; vdd_uv_flag = 1'b0;
            wait_cyc(4);
            check("R4", $sformatf("latch kept/wiped combo %0d", c), fault_code, bl ? 3 : 0);
        end

        // clear pulse of exactly SLEEP_CNT samples
        latch_boot(2'b01);
        check("R4", "phase 0 latched", fault_code, 3);
        wake_low(SLEEP_CNT, saw);
        check("R8", "no sleep at SLEEP_CNT", saw, 0);
        check("R8", "latch cleared by pulse", fault_code, 0);

        // one more sample enters sleep
        latch_boot(2'b10);
        wake_low(SLEEP_CNT + 1, saw);
        check("R9", "sleep at SLEEP_CNT+1", saw, 1);
        wait_cyc(SETTLE_CNT + 2);
        check("R9", "latch cleared by sleep", fault_code, 0);

        // long sleep with faults presented
        latch_boot(2'b11);
        wake_n = 1'b0;
        wait_cyc(SLEEP_CNT + 6);
        ot_flag = 1'b1;
        latch_boot(2'b11);
        check("R9", "sleep flag", sleep, 1);
        check("R9", "out_dis in sleep", out_dis, 1);
        check("R9", "fault_n released in sleep", fault_n, 1);
        check("R9", "code in sleep", fault_code, 0);
        ot_flag = 1'b0;
        wait_cyc(3);
        wake_n = 1'b1;
        inh_cnt = 0; dis_cnt = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (cp_inhibit) inh_cnt++;
            if (cp_inhibit && out_dis) dis_cnt++;
        end
        check("R10", "inhibit cycles", inh_cnt, SETTLE_CNT);
        check("R10", "disabled inhibit cycles", dis_cnt, SETTLE_CNT);
        check("R10", "out_dis after settle", out_dis, 0);
        check("R9", "timeouts in sleep ignored", fault_code, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule